// File: doc/BRIEF.md
# Decimal-Set Filter Clock Synthesizer Controller

This block is the digital half of a phase-locked frequency synthesizer that clocks a switched-capacitor filter. The filter's cutoff is one hundredth of its clock, so the block sets the clock as a whole number of 10 kHz steps. Each step is a 100 Hz move in cutoff. The step count is the feedback ratio. It is given as two decimal digits, and those digits read directly as the cutoff in kHz: tens 3 and ones 0 mean 3.0 kHz, a 300 kHz clock and a ratio of 30.

A fixed counter divides the system clock by `REF_DIV`, which is 2700 for a 27 MHz clock, to give a single-cycle reference tick every 10 kHz. The digits come from one of two sources. The first is a small write port with a one-bit address that picks the digit. The second is a pair of rotary decimal switch inputs, chosen by a select pin. The VCO output comes back on `vco_in`. It is synchronised, and each rising edge is counted. A feedback tick is issued once every `ratio_now` edges. A three-state phase-frequency detector compares the two ticks and drives pump-up and pump-down outputs toward the analog loop filter. A two-state lock monitor watches how wide those pulses are in each reference period.

The PFD states are PFD_IDLE, PFD_UP and PFD_DN, with these transitions:
- PFD_IDLE goes to PFD_UP on a reference tick alone, and to PFD_DN on a feedback tick alone. It stays in PFD_IDLE when both ticks come together.
- PFD_UP goes back to PFD_IDLE on a feedback tick. This is the clear that follows once both events have been seen.
- PFD_DN goes back to PFD_IDLE on a reference tick.

The lock monitor states are LK_HUNT and LK_LOCKED. It moves from LK_HUNT to LK_LOCKED after `LOCK_PERIODS` narrow periods in a row. It moves from LK_LOCKED back to LK_HUNT on the first wide period.

Top module: `scf_synth_ctrl`

## Requirements
- R1: `ref_tick` is high for exactly one cycle in every `REF_DIV` cycles. The first tick comes in cycle `REF_DIV`-1 after reset is released.
- R2: A write with `cpu_addr`=0 loads the ones digit, and a write with `cpu_addr`=1 loads the tens digit. When the write source is selected, `ratio_sel` shows 10×tens+ones two cycles after the write edge.
- R3: A written digit value above 9 is dropped, and the stored digit keeps its previous value.
- R4: With `use_switches`=1, the ratio is taken from `sw_tens`/`sw_ones`, and `ratio_sel` follows them one cycle later. With `use_switches`=0, the stored written digits are used again.
- R5: A selected ratio of 0 or 1, or a switch digit above 9, is invalid. In that case `ratio_sel` keeps the last valid ratio and `ratio_bad` is high. `ratio_bad` is low whenever the selected ratio is valid.
- R6: `fb_tick` is a one-cycle pulse issued once every `ratio_now` rising edges of `vco_in`. It comes three cycles after the edge that completes the count.
- R7: `ratio_now` takes the value of `ratio_sel` only at a feedback terminal count. A count already in progress finishes with the old ratio.
- R8: `pump_up` rises the cycle after a reference tick, and `pump_dn` rises the cycle after a feedback tick. An opposite tick returns both to low. The two outputs are never high together.
- R9: `locked` rises only after `LOCK_PERIODS` (16) consecutive reference periods, each with fewer than `WIDTH_LIMIT` (8) cycles of pump activity. It falls at the end of the first period that reaches the limit.
- R10: During and after reset, `ratio_sel` and `ratio_now` are 30 (stored digits tens 3, ones 0). `pump_up`, `pump_dn`, `locked` and `ratio_bad` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Digit write strobe |
| cpu_addr | input | 1 | Digit select: 0 ones, 1 tens |
| cpu_data | input | 4 | Digit value to write |
| use_switches | input | 1 | 1 selects the switch digits as source |
| sw_tens | input | 4 | Tens digit from the rotary switch |
| sw_ones | input | 4 | Ones digit from the rotary switch |
| vco_in | input | 1 | Returning VCO clock, asynchronous |
| ref_tick | output | 1 | 10 kHz reference pulse |
| fb_tick | output | 1 | Divided feedback pulse |
| pump_up | output | 1 | Charge pump raise request |
| pump_dn | output | 1 | Charge pump lower request |
| locked | output | 1 | Loop lock indication |
| ratio_bad | output | 1 | Selected ratio is invalid |
| ratio_sel | output | 7 | Last valid selected ratio |
| ratio_now | output | 7 | Ratio the feedback divider is using |

## Verification
Each result has a fixed delay after its stimulus:
- A digit write shows on `ratio_sel` and `ratio_bad` two edges after the write edge. A switch change shows one edge after the change.
- `fb_tick` appears three edges after the VCO edge that completes the count.
- A pump output starts one edge after its tick.
- A lock decision is made only at a reference tick.

The bench sets inputs at falling edges and samples outputs at falling edges. For register values it waits three cycles, which is past the latest due time. It measures divider ratios by counting the model's own VCO edges between observed feedback pulses, so the constant synchroniser delay cancels out. It checks lock only at counted reference ticks. A behavioural loop in the bench adjusts the VCO phase by the pump outputs, which lets lock both be acquired and be broken on purpose.

// File: rtl/scf_synth_pkg.sv
`timescale 1ns/1ps
package scf_synth_pkg;
    localparam int unsigned RATIO_W = 7;
    localparam int unsigned DIGIT_W = 4;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2
    } pfd_state_t;

    typedef enum logic {
        LK_HUNT   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_t;

    localparam digit_t RESET_TENS  = 4'd3;
    localparam digit_t RESET_ONES  = 4'd0;
    localparam ratio_t RESET_RATIO = 7'd30;
    localparam digit_t DIGIT_MAX   = 4'd9;

    function automatic ratio_t digits_to_ratio(input digit_t tens, input digit_t ones);
        return ratio_t'(tens) * ratio_t'(10) + ratio_t'(ones);
    endfunction
endpackage

// File: rtl/scf_ref_divider.sv
`timescale 1ns/1ps
module scf_ref_divider #(
    parameter int unsigned DIV = 2700
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/scf_ratio_source.sv
`timescale 1ns/1ps
module scf_ratio_source
    import scf_synth_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cpu_wr,
    input  logic   cpu_addr,
    input  digit_t cpu_data,
    input  logic   use_switches,
    input  digit_t sw_tens,
    input  digit_t sw_ones,
    output ratio_t held_ratio,
    output logic   held_bad
);
    digit_t ones_q, tens_q;
    digit_t pick_tens, pick_ones;
    logic   pick_invalid;
    ratio_t pick_ratio;

    // stored digits; a value above nine never lands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= RESET_ONES;
            tens_q <= RESET_TENS;
        end else if (cpu_wr && (cpu_data <= DIGIT_MAX)) begin
            if (cpu_addr) begin
                tens_q <= cpu_data;
            end else begin
                ones_q <= cpu_data;
            end
        end
    end

    always_comb begin
        pick_tens    = use_switches ? sw_tens : tens_q;
        pick_ones    = use_switches ? sw_ones : ones_q;
        pick_ratio   = digits_to_ratio(pick_tens, pick_ones);
        pick_invalid = (pick_tens > DIGIT_MAX) || (pick_ones > DIGIT_MAX) ||
                       ((pick_tens == '0) && (pick_ones < 4'd2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_ratio <= RESET_RATIO;
            held_bad   <= 1'b0;
        end else begin
            held_bad <= pick_invalid;
            if (!pick_invalid) begin
                held_ratio <= pick_ratio;
            end
        end
    end
endmodule

// File: rtl/scf_fb_divider.sv
`timescale 1ns/1ps
module scf_fb_divider
    import scf_synth_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   vco_in,
    input  ratio_t next_ratio,
    output ratio_t active_ratio,
    output logic   tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic                   terminal;
    ratio_t                 cnt_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= vco_in;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], vco_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise     = sync_q[SYNC_STAGES-1] && !prev_q;
    assign terminal = rise && (cnt_q == active_ratio - ratio_t'(1));

    // the new ratio is adopted only on the terminal edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            active_ratio <= RESET_RATIO;
            tick         <= 1'b0;
        end else begin
            tick <= terminal;
            if (terminal) begin
                cnt_q        <= '0;
                active_ratio <= next_ratio;
            end else if (rise) begin
                cnt_q <= cnt_q + ratio_t'(1);
            end
        end
    end
endmodule

// File: rtl/scf_pfd.sv
`timescale 1ns/1ps
module scf_pfd
    import scf_synth_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic fb_ev,
    output logic up,
    output logic dn
);
    pfd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PFD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PFD_IDLE: begin
                if (ref_ev && !fb_ev)      state_d = PFD_UP;
                else if (fb_ev && !ref_ev) state_d = PFD_DN;
            end
            PFD_UP:   if (fb_ev)  state_d = PFD_IDLE;
            PFD_DN:   if (ref_ev) state_d = PFD_IDLE;
            default:  state_d = PFD_IDLE;
        endcase
    end

    always_comb begin
        up = (state_q == PFD_UP);
        dn = (state_q == PFD_DN);
    end
endmodule

// File: rtl/scf_lock_detect.sv
`timescale 1ns/1ps
module scf_lock_detect
    import scf_synth_pkg::*;
#(
    parameter int unsigned LOCK_PERIODS = 16,
    parameter int unsigned WIDTH_LIMIT  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic up,
    input  logic dn,
    output logic locked
);
    localparam int unsigned AW = $clog2(WIDTH_LIMIT + 1);
    localparam int unsigned GW = $clog2(LOCK_PERIODS + 1);
    localparam logic [AW-1:0] LIMIT = AW'(WIDTH_LIMIT);
    localparam logic [GW-1:0] GOAL  = GW'(LOCK_PERIODS - 1);

    lock_state_t   state_q, state_d;
    logic [AW-1:0] width_q;
    logic [GW-1:0] good_q;
    logic          wide;

    assign wide = (width_q >= LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_HUNT:   if (ref_ev && !wide && (good_q == GOAL)) state_d = LK_LOCKED;
            LK_LOCKED: if (ref_ev && wide)                      state_d = LK_HUNT;
            default:   state_d = LK_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            good_q  <= '0;
        end else if (ref_ev) begin
            width_q <= '0;
            if (wide)               good_q <= '0;
            else if (good_q < GOAL) good_q <= good_q + 1'b1;
        end else if ((up || dn) && !wide) begin
            width_q <= width_q + 1'b1;
        end
    end

    always_comb begin
        locked = (state_q == LK_LOCKED);
    end
endmodule

// File: rtl/scf_synth_ctrl.sv
`timescale 1ns/1ps
module scf_synth_ctrl #(
    parameter int unsigned REF_DIV      = 2700,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned LOCK_PERIODS = 16,
    parameter int unsigned WIDTH_LIMIT  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_wr,
    input  logic       cpu_addr,
    input  logic [3:0] cpu_data,
    input  logic       use_switches,
    input  logic [3:0] sw_tens,
    input  logic [3:0] sw_ones,
    input  logic       vco_in,
    output logic       ref_tick,
    output logic       fb_tick,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       locked,
    output logic       ratio_bad,
    output logic [6:0] ratio_sel,
    output logic [6:0] ratio_now
);
    scf_ref_divider #(.DIV(REF_DIV)) i_ref (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ref_tick)
    );

    scf_ratio_source i_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr      (cpu_wr),
        .cpu_addr    (cpu_addr),
        .cpu_data    (cpu_data),
        .use_switches(use_switches),
        .sw_tens     (sw_tens),
        .sw_ones     (sw_ones),
        .held_ratio  (ratio_sel),
        .held_bad    (ratio_bad)
    );

    scf_fb_divider #(.SYNC_STAGES(SYNC_STAGES)) i_fb (
        .clk         (clk),
        .rst_n       (rst_n),
        .vco_in      (vco_in),
        .next_ratio  (ratio_sel),
        .active_ratio(ratio_now),
        .tick        (fb_tick)
    );

    scf_pfd i_pfd (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_ev(ref_tick),
        .fb_ev (fb_tick),
        .up    (pump_up),
        .dn    (pump_dn)
    );

    scf_lock_detect #(
        .LOCK_PERIODS(LOCK_PERIODS),
        .WIDTH_LIMIT (WIDTH_LIMIT)
    ) i_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_ev(ref_tick),
        .up    (pump_up),
        .dn    (pump_dn),
        .locked(locked)
    );
endmodule

// File: rtl/scf_synth_checker.sv
`timescale 1ns/1ps
module scf_synth_checker #(
    parameter int unsigned REF_DIV = 2700
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_tick,
    input logic       fb_tick,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       locked,
    input logic       ratio_bad,
    input logic [6:0] ratio_sel,
    input logic [6:0] ratio_now
);
    int unsigned gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gap_q <= 0;
        else if (ref_tick) gap_q <= 0;
        else               gap_q <= gap_q + 1;
    end

    a_r1_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |-> (gap_q == REF_DIV - 1));
    a_r1_ref_due: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == REF_DIV - 1) |-> ref_tick);
    a_r5_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_sel >= 7'd2) && (ratio_sel <= 7'd99));
    a_r5_bad_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_bad |-> $stable(ratio_sel));
    a_r6_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |=> !fb_tick);
    a_r7_swap_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_now) |-> fb_tick);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));
    a_r8_ref_raises_up: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick && !fb_tick && !pump_up && !pump_dn) |=> pump_up);
    a_r9_lock_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(ref_tick));
endmodule

bind scf_synth_ctrl scf_synth_checker #(.REF_DIV(REF_DIV)) i_chk (.*);

// File: tb/test_scf_synth_ctrl.sv
`timescale 1ns/1ps
module test_scf_synth_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int REF_DIV    = 2700;
    localparam int WATCHDOG   = 195000;

    typedef struct packed {
        logic       sel_sw;
        logic       wr;
        logic       addr;
        logic [3:0] data;
        logic [3:0] st;
        logic [3:0] so;
        logic [6:0] held;
        logic       bad;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 4'd4,  4'd0,  4'd0, 7'd40, 1'b0},
        '{1'b0, 1'b1, 1'b0, 4'd5,  4'd0,  4'd0, 7'd45, 1'b0},
        '{1'b0, 1'b1, 1'b0, 4'd12, 4'd0,  4'd0, 7'd45, 1'b0},
        '{1'b0, 1'b1, 1'b1, 4'd0,  4'd0,  4'd0, 7'd5,  1'b0},
        '{1'b0, 1'b1, 1'b0, 4'd1,  4'd0,  4'd0, 7'd5,  1'b1},
        '{1'b0, 1'b1, 1'b0, 4'd0,  4'd0,  4'd0, 7'd5,  1'b1},
        '{1'b0, 1'b1, 1'b0, 4'd2,  4'd0,  4'd0, 7'd2,  1'b0},
        '{1'b0, 1'b1, 1'b1, 4'd9,  4'd0,  4'd0, 7'd92, 1'b0},
        '{1'b0, 1'b1, 1'b0, 4'd9,  4'd0,  4'd0, 7'd99, 1'b0},
        '{1'b0, 1'b1, 1'b1, 4'd15, 4'd0,  4'd0, 7'd99, 1'b0},
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd3,  4'd1, 7'd31, 1'b0},
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  4'd1, 7'd31, 1'b1},
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd10, 4'd2, 7'd31, 1'b1},
        '{1'b1, 1'b0, 1'b0, 4'd0,  4'd2,  4'd7, 7'd27, 1'b0},
        '{1'b0, 1'b0, 1'b0, 4'd0,  4'd0,  4'd0, 7'd99, 1'b0},
        '{1'b0, 1'b1, 1'b1, 4'd3,  4'd0,  4'd0, 7'd39, 1'b0},
        '{1'b0, 1'b1, 1'b0, 4'd0,  4'd0,  4'd0, 7'd30, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_addr = 1'b0;
    logic [3:0] cpu_data = '0;
    logic       use_switches = 1'b0;
    logic [3:0] sw_tens = '0;
    logic [3:0] sw_ones = '0;
    logic       vco_in = 1'b0;
    logic       ref_tick, fb_tick, pump_up, pump_dn, locked, ratio_bad;
    logic [6:0] ratio_sel, ratio_now;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural VCO and observation state
    bit vco_run = 1'b0;
    bit jump_req = 1'b0;
    bit dn_seen = 1'b0;
    int model_ratio = 30;
    int acc = 0;
    int edges = 0;
    int n_int = 0;
    int ref_count = 0;
    int cyc = 0;
    int intv [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    scf_synth_ctrl i_scf_synth_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .use_switches(use_switches), .sw_tens(sw_tens),
        .sw_ones(sw_ones), .vco_in(vco_in), .ref_tick(ref_tick), .fb_tick(fb_tick),
        .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked), .ratio_bad(ratio_bad),
        .ratio_sel(ratio_sel), .ratio_now(ratio_now)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    function automatic string vec_tag(input int i);
        if (i == 2 || i == 9)                     return "R3 digit above nine dropped";
        if (i == 4 || i == 5 || i == 11 || i == 12) return "R5 invalid ratio held";
        if (i >= 10 && i <= 14)                   return "R4 switch source";
        return "R2 digit write";
    endfunction

    // first-order loop: pump outputs speed up or slow down the phase
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (vco_run) begin
                if (jump_req && acc < REF_DIV) begin
                    acc += REF_DIV;
                    jump_req = 1'b0;
                end
                acc += pump_up ? 3 * model_ratio : (pump_dn ? model_ratio : 2 * model_ratio);
                if (acc >= 2 * REF_DIV) acc -= 2 * REF_DIV;
                if ((acc >= REF_DIV) && !vco_in) edges++;
                vco_in = (acc >= REF_DIV);
            end
            if (pump_dn) dn_seen = 1'b1;
            if (fb_tick) begin
                if (n_int < 256) intv[n_int] = edges;
                n_int++;
                edges = 0;
            end
            if (ref_tick) ref_count++;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0, rc0, k;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(ratio_sel == 7'd30, "R10 reset ratio_sel", ratio_sel, 30);
        check(ratio_now == 7'd30, "R10 reset ratio_now", ratio_now, 30);
        check(!pump_up && !pump_dn, "R10 reset pumps", {pump_up, pump_dn}, 0);
        check(!locked, "R10 reset lock", locked, 0);
        check(!ratio_bad, "R10 reset bad flag", ratio_bad, 0);
        rst_n = 1'b1;

        // table walk: digit writes, switch source, invalid ratios
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            use_switches = VECS[i].sel_sw;
            sw_tens      = VECS[i].st;
            sw_ones      = VECS[i].so;
            if (VECS[i].wr) begin
                cpu_wr   = 1'b1;
                cpu_addr = VECS[i].addr;
                cpu_data = VECS[i].data;
                @(negedge clk);
                cpu_wr = 1'b0;
            end
            repeat (3) @(negedge clk);
            check(ratio_sel == VECS[i].held, vec_tag(i), ratio_sel, VECS[i].held);
            check(ratio_bad == VECS[i].bad, vec_tag(i), ratio_bad, VECS[i].bad);
        end

        // R1 reference spacing and R8 up after a lone reference tick
        do @(negedge clk); while (!ref_tick);
        t0 = cyc;
        @(negedge clk);
        check(pump_up && !pump_dn, "R8 up after reference tick", {pump_up, pump_dn}, 2);
        do @(negedge clk); while (!ref_tick);
        check(cyc - t0 == REF_DIV, "R1 reference period", cyc - t0, REF_DIV);

        // R9 acquisition with the loop closed at ratio 30
        model_ratio = 30;
        acc = 0;
        rc0 = ref_count;
        vco_run = 1'b1;
        while (ref_count < rc0 + 15) @(negedge clk);
        check(!locked, "R9 no lock before 16 narrow periods", locked, 0);
        while (!locked && ref_count < rc0 + 60) @(negedge clk);
        check(locked, "R9 lock acquired", locked, 1);

        // R6 division by 30
        k = n_int;
        while (n_int < k + 3) @(negedge clk);
        check(intv[k + 1] == 30, "R6 feedback interval", intv[k + 1], 30);
        check(intv[k + 2] == 30, "R6 feedback interval", intv[k + 2], 30);

        // R9 lock loss and R8 down pulse after a forward phase step
        dn_seen = 1'b0;
        jump_req = 1'b1;
        rc0 = ref_count;
        while (ref_count < rc0 + 3) @(negedge clk);
        check(!locked, "R9 lock dropped on wide period", locked, 0);
        check(dn_seen, "R8 down pulse on early feedback", dn_seen, 1);

        // R7 new ratio applied at terminal count only
        k = n_int;
        wait (n_int > k);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 1'b0; cpu_data = 4'd1;
        model_ratio = 31;
        k = n_int;
        @(negedge clk);
        cpu_wr = 1'b0;
        while (n_int < k + 3) @(negedge clk);
        check(intv[k] == 30, "R7 count in progress keeps old ratio", intv[k], 30);
        check(intv[k + 1] == 31, "R7 new ratio after terminal", intv[k + 1], 31);
        check(intv[k + 2] == 31, "R7 new ratio steady", intv[k + 2], 31);
        check(ratio_now == 7'd31, "R7 ratio_now updated", ratio_now, 31);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule